// File: doc/BRIEF.md
# Binary XNOR-Popcount Neuron Array

This block is a small arithmetic engine for binary neural networks. It holds eight neurons. Each neuron stores one weight byte and keeps a running 10-bit sum. A host streams activation bytes over an 8-bit bus. On each rising edge of a compute enable, every neuron does three things at once. It forms the bitwise XNOR of the activation byte with its own weight byte. It counts the one bits in that result. It adds the count to its own sum.

The same byte bus also loads weights. While the load strobe is high, the byte on the bus is written into the weight register of the neuron picked by a 3-bit address, one byte per clock. That address also selects which neuron's sum appears on the outputs. The low eight bits go to the result bus, and the top two bits go to bits 7 and 6 of the side output group.

The block has no sequencer. The host decides the order of weight loads, activation bytes, readouts and resets. It also handles layer looping, thresholds and the final output layer.

Top module: `bnn_xnor_array`

## Requirements
- R1: While `rst_n` is low, every accumulator and every weight register is cleared to zero. A compute edge after reset therefore adds 8 to each neuron when the activation byte is 0x00.
- R2: On a clock edge with `side_in[0]` (load) high, the weight register of the neuron numbered `side_in[3:1]` takes `act_bus`. The weights of the other seven neurons are unchanged.
- R3: On a clock edge where `side_in[4]` (compute) is high, was low at the previous edge, and load is low, every neuron adds to its accumulator the number of bit positions where `act_bus` equals its weight byte (0 to 8).
- R4: Holding `side_in[4]` high over several clock edges causes exactly one accumulation, at the first of those edges.
- R5: A compute rising edge that arrives in a clock edge with load high causes no accumulation in any neuron. That edge is used up and is not deferred.
- R6: The outputs show the accumulator of neuron `side_in[3:1]` combinationally. Bits 7:0 appear on `acc_low` and bits 9:8 appear on `side_out[7:6]`.
- R7: `side_oe` is 8'hC0, so only bits 7 and 6 of the side group are driven. `side_out[5:0]` reads zero.
- R8: Accumulators wrap modulo 1024. After 127 full-match accumulations a neuron holds 1016, and after three more it holds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears accumulators and weights |
| act_bus | input | 8 | Activation byte or weight byte |
| side_in | input | 8 | Bit 0 load, bits 3:1 neuron address, bit 4 compute; bits 7:5 ignored |
| acc_low | output | 8 | Bits 7:0 of the selected accumulator |
| side_out | output | 8 | Bits 7:6 carry accumulator bits 9:8; bits 5:0 zero |
| side_oe | output | 8 | Output enables for the side group, fixed at 8'hC0 |

## Verification
The table pairs weight and activation bytes that give counts of 8, 0, 4, 6 and 7. One pair is all zeros against all zeros: it yields 8 under XNOR but 0 under AND, which shows whether the product is XNOR or a plain AND or XOR. A second pattern loads a different weight into each neuron and streams several bytes. Checking all eight sums shows whether each neuron uses its own weight and whether the address decode and the readout select agree. Directed tests hold compute high over many cycles, raise compute during a load, and run a neuron past 1023 to show the wrap.

// File: rtl/bnn_pkg.sv
`timescale 1ns/1ps
package bnn_pkg;
    localparam int NEURON_CNT = 8;
    localparam int DATA_W     = 8;
    localparam int ACC_W      = 10;
    localparam int SEL_W      = $clog2(NEURON_CNT);
    localparam int CNT_W      = $clog2(DATA_W + 1);

    // side group bit positions
    localparam int SIDE_LOAD  = 0;
    localparam int SIDE_SEL0  = 1;
    localparam int SIDE_COMP  = 4;
    localparam int SIDE_HI0   = 6;
endpackage

// File: rtl/bnn_rise_det.sv
`timescale 1ns/1ps
module bnn_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign pulse = level & ~level_q;
endmodule

// File: rtl/bnn_neuron.sv
`timescale 1ns/1ps
module bnn_neuron #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              add_en,
    input  logic [DATA_W-1:0] din,
    output logic [ACC_W-1:0]  acc_q
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] wgt_q;
    logic [DATA_W-1:0] agree;
    logic [CNT_W-1:0]  ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wgt_q <= '0;
        else if (wr_en) wgt_q <= din;
    end

    assign agree = ~(din ^ wgt_q);

    always_comb begin
        ones = '0;
        for (int b = 0; b < DATA_W; b++) begin
            ones = ones + CNT_W'(agree[b]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (add_en) acc_q <= acc_q + ACC_W'(ones);
    end
endmodule

// File: rtl/bnn_acc_select.sv
`timescale 1ns/1ps
module bnn_acc_select #(
    parameter int COUNT = 8,
    parameter int ACC_W = 10,
    localparam int SEL_W = $clog2(COUNT)
) (
    input  logic [COUNT-1:0][ACC_W-1:0] acc_vec,
    input  logic [SEL_W-1:0]            sel,
    output logic [ACC_W-1:0]            acc_sel
);
    always_comb begin
        acc_sel = '0;
        for (int k = 0; k < COUNT; k++) begin
            if (sel == SEL_W'(k)) acc_sel = acc_vec[k];
        end
    end
endmodule

// File: rtl/bnn_xnor_array.sv
`timescale 1ns/1ps
module bnn_xnor_array
    import bnn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] act_bus,
    input  logic [7:0] side_in,
    output logic [7:0] acc_low,
    output logic [7:0] side_out,
    output logic [7:0] side_oe
);
    logic              load_w;
    logic              comp_lvl;
    logic              comp_rise;
    logic              add_all;
    logic [SEL_W-1:0]  sel;
    logic [NEURON_CNT-1:0][ACC_W-1:0] acc_vec;
    logic [ACC_W-1:0]  acc_sel;
    logic              unused_side;

    assign load_w      = side_in[SIDE_LOAD];
    assign sel         = side_in[SIDE_SEL0 +: SEL_W];
    assign comp_lvl    = side_in[SIDE_COMP];
    assign unused_side = ^side_in[7:5];

    bnn_rise_det u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (comp_lvl),
        .pulse (comp_rise)
    );

    // a load cycle swallows any compute edge
    assign add_all = comp_rise & ~load_w;

    for (genvar n = 0; n < NEURON_CNT; n++) begin : g_neuron
        bnn_neuron #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_neuron (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (load_w && (sel == SEL_W'(n))),
            .add_en (add_all),
            .din    (act_bus),
            .acc_q  (acc_vec[n])
        );
    end

    bnn_acc_select #(
        .COUNT (NEURON_CNT),
        .ACC_W (ACC_W)
    ) u_sel (
        .acc_vec (acc_vec),
        .sel     (sel),
        .acc_sel (acc_sel)
    );

    assign acc_low  = acc_sel[7:0];
    assign side_out = {acc_sel[ACC_W-1:8], 6'b0};
    assign side_oe  = 8'b1100_0000;
endmodule

// File: rtl/bnn_xnor_array_chk.sv
`timescale 1ns/1ps
module bnn_xnor_array_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] side_in,
    input logic [7:0] acc_low,
    input logic [7:0] side_out
);
    logic [9:0] res;
    assign res = {side_out[7:6], acc_low};

    // R1: outputs read zero on the first edge after reset release
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (res == 10'd0));

    // R3: one edge adds at most 8 to the shown neuron
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(side_in[3:1]))
            |-> (((res - $past(res)) & 10'h3FF) <= 10'd8));

    // R4: compute held high adds nothing further
    p_hold_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && side_in[4] && $past(side_in[4]))
            |=> (!$stable(side_in[3:1]) || $stable(res)));

    // R5: a load cycle never accumulates
    p_load_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        side_in[0] |=> (!$stable(side_in[3:1]) || $stable(res)));
endmodule

bind bnn_xnor_array bnn_xnor_array_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .side_in  (side_in),
    .acc_low  (acc_low),
    .side_out (side_out)
);

// File: tb/test_bnn_xnor_array.sv
`timescale 1ns/1ps
module test_bnn_xnor_array;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] act_bus = '0;
    logic       load = 1'b0;
    logic       comp = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] side_in;
    logic [7:0] acc_low, side_out, side_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] w_m [8];
    logic [9:0] a_m [8];

    assign side_in = {3'b000, comp, addr, load};

    always #5 clk = ~clk;

    bnn_xnor_array i_bnn_xnor_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_bus  (act_bus),
        .side_in  (side_in),
        .acc_low  (acc_low),
        .side_out (side_out),
        .side_oe  (side_oe)
    );

    // {weight, activation, expected count}
    localparam logic [19:0] VEC [6] = '{
        {8'hFF, 8'hFF, 4'd8},
        {8'h00, 8'hFF, 4'd0},
        {8'hA5, 8'h0F, 4'd4},
        {8'h00, 8'h00, 4'd8},
        {8'h3C, 8'h30, 4'd6},
        {8'h81, 8'h01, 4'd7}
    };

    function automatic logic [3:0] match_cnt(logic [7:0] a, logic [7:0] w);
        logic [3:0] c = '0;
        for (int b = 0; b < 8; b++) c = c + 4'(a[b] == w[b]);
        return c;
    endfunction

    task automatic chk(string req, logic [9:0] got, logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; load = 1'b0; comp = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) begin w_m[n] = '0; a_m[n] = '0; end
        tick();
    endtask

    task automatic load_w(int n, logic [7:0] b);
        load = 1'b1; addr = 3'(n); act_bus = b;
        tick();
        load = 1'b0;
        w_m[n] = b;
    endtask

    task automatic pulse(logic [7:0] b);
        act_bus = b; comp = 1'b1;
        tick();
        comp = 1'b0;
        tick();
        for (int n = 0; n < 8; n++) a_m[n] = a_m[n] + 10'(match_cnt(b, w_m[n]));
    endtask

    task automatic read(int n, string req, logic [9:0] exp);
        addr = 3'(n);
        #1;
        chk(req, {side_out[7:6], acc_low}, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state on every neuron, R7 fixed enables and zero low side bits
        for (int n = 0; n < 8; n++) read(n, "R1", 10'd0);
        chk("R7", {2'b00, side_oe}, 10'h0C0);
        chk("R7", {4'b0, side_out[5:0]}, 10'd0);
        // R1 weights cleared: zero byte matches all eight bits
        pulse(8'h00);
        for (int n = 0; n < 8; n++) read(n, "R1", 10'd8);

        // table walk: R3 count per pair
        for (int i = 0; i < 6; i++) begin
            do_reset();
            load_w(i, VEC[i][19:12]);
            pulse(VEC[i][11:4]);
            read(i, "R3", {6'b0, VEC[i][3:0]});
            chk("R3", a_m[i], {6'b0, VEC[i][3:0]});
        end

        // R2 and R6: distinct weight per neuron, several bytes, read all
        do_reset();
        for (int n = 0; n < 8; n++) load_w(n, 8'(8'h11 * n + 8'h07));
        pulse(8'h5A); pulse(8'hC3); pulse(8'h07); pulse(8'hFF);
        for (int n = 0; n < 8; n++) read(n, "R6", a_m[n]);
        // R2 reload only neuron 3, others keep their weight
        load_w(3, 8'hE1);
        pulse(8'hE1);
        for (int n = 0; n < 8; n++) read(n, "R2", a_m[n]);

        // R4 compute held for many edges
        do_reset();
        load_w(0, 8'hFF);
        act_bus = 8'hFF; comp = 1'b1;
        for (int k = 0; k < 6; k++) tick();
        comp = 1'b0; tick();
        read(0, "R4", 10'd8);

        // R5 compute rises during a load cycle
        do_reset();
        load = 1'b1; addr = 3'd2; act_bus = 8'hF0; comp = 1'b1;
        tick();
        load = 1'b0;
        tick();
        comp = 1'b0; tick();
        w_m[2] = 8'hF0;
        for (int n = 0; n < 8; n++) read(n, "R5", 10'd0);
        pulse(8'hF0);
        read(2, "R5", 10'd8);

        // R8 wrap at 1024
        do_reset();
        load_w(5, 8'h96);
        for (int k = 0; k < 127; k++) pulse(8'h96);
        read(5, "R8", 10'd1016);
        for (int k = 0; k < 3; k++) pulse(8'h96);
        read(5, "R8", 10'd16);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule